// File: doc/BRIEF.md
# Triggered Multi-Frame Window Capture

This block sits on a continuous stream of packed complex samples, four per clock, and turns a single trigger pulse into one bounded capture window on an AXI4-Stream master. The window holds a programmed number of frames. Each frame is 512 samples, which is 128 output beats. When the last beat of the window has been accepted, the block raises a one-cycle completion pulse and returns to idle. A downstream stream-to-memory engine would normally follow it.

The trigger has no relation to the upstream frame structure. Frame boundaries on the output are counted from the first beat captured, not from any upstream marker. So the first output frame, like every other, can straddle two upstream frame regions. The frame count is sampled when the trigger is accepted. While the block is idle, the upstream stream is accepted and thrown away, so the source never stalls. During a window, beats move only on a valid-ready handshake, and the downstream ready is passed straight back to the source.

Top module: `win_capture`

## Requirements
- R1: After an accepted trigger, exactly n_frames × 128 beats are handshaken on the master port. n_frames is sampled in the trigger cycle, and later changes to it have no effect on the running window.
- R2: m_tlast is high on accepted beats 128, 256, … counted from the first captured beat, and on no other beat. An output frame can therefore hold beats from two upstream frames.
- R3: Capture begins with the first input beat that follows the trigger cycle, with no wait for alignment. The beat present in the trigger cycle itself is dropped.
- R4: A trigger while busy is high is ignored, including in the cycle that carries the final beat. A trigger is accepted whenever busy is low, including the cycle in which done is high.
- R5: done is high for exactly one cycle, in the cycle after the final beat is accepted. busy falls on the same edge.
- R6: While busy, m_tvalid follows s_valid, s_ready follows m_tready, and m_tdata equals s_data. Beats are forwarded in order, with none lost or repeated. Lane k occupies bits [32k+31:32k], with the real part in the low 16 bits and the imaginary part in the high 16 bits.
- R7: While busy is low, s_ready is 1 and m_tvalid is 0, so input beats are dropped.
- R8: A trigger with n_frames equal to 0 starts nothing. Neither busy nor done rises.
- R9: After reset, busy, done, m_tvalid and m_tlast are 0.
- R10: The default 11-bit n_frames port supports windows of at least 1024 frames (131072 beats).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 128 | Four packed complex samples from upstream |
| s_valid | input | 1 | Upstream beat valid |
| s_ready | output | 1 | Upstream beat accepted (held high while idle) |
| trig | input | 1 | Capture trigger pulse |
| n_frames | input | 11 | Frames per window, sampled at trigger |
| m_tdata | output | 128 | Stream data out |
| m_tvalid | output | 1 | Stream valid out |
| m_tready | input | 1 | Stream ready from downstream |
| m_tlast | output | 1 | Last beat of a frame |
| busy | output | 1 | Window in progress |
| done | output | 1 | One-cycle window completion pulse |

## Verification
Two situations put the window's end in the same cycle as the trigger logic. In the first, a trigger arrives in the very cycle that carries the final handshaken beat. In the second, a trigger arrives in the cycle where done is high. The bench produces the first by driving the trigger on the beat it predicts to be the last, with ready and valid held high. It judges the result by checking that busy stays low in the cycle after done. It produces the second by driving the trigger together with the done cycle it expects, and requires busy to rise and a fresh one-frame window to follow.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
   typedef enum logic [0:0] {
      CAP_IDLE = 1'b0,
      CAP_RUN  = 1'b1
   } cap_state_e;
endpackage

// File: rtl/wcap_wrap_cnt.sv
module wcap_wrap_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   input  logic [W-1:0] last_val,
   output logic [W-1:0] cnt,
   output logic         at_last
);
   assign at_last = (cnt == last_val);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
      end else if (inc) begin
         cnt <= at_last ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/wcap_ctrl.sv
module wcap_ctrl
   import wcap_pkg::*;
#(
   parameter int NF_W = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trig,
   input  logic [NF_W-1:0] n_frames,
   input  logic            final_beat,
   output logic            busy,
   output logic            done,
   output logic            start,
   output logic [NF_W-1:0] nf_q
);
   cap_state_e state;

   assign busy  = (state == CAP_RUN);
   assign start = (state == CAP_IDLE) && trig && (n_frames != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= CAP_IDLE;
         done  <= 1'b0;
         nf_q  <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            CAP_IDLE: begin
               if (start) begin
                  state <= CAP_RUN;
                  nf_q  <= n_frames;
               end
            end
            CAP_RUN: begin
               if (final_beat) begin
                  state <= CAP_IDLE;
                  done  <= 1'b1;
               end
            end
            default: state <= CAP_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/win_capture.sv
module win_capture #(
   parameter int LANES         = 4,
   parameter int SAMPLE_W      = 32,
   parameter int FRAME_SAMPLES = 512,
   parameter int NF_W          = 11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANES*SAMPLE_W-1:0] s_data,
   input  logic                      s_valid,
   output logic                      s_ready,
   input  logic                      trig,
   input  logic [NF_W-1:0]           n_frames,
   output logic [LANES*SAMPLE_W-1:0] m_tdata,
   output logic                      m_tvalid,
   input  logic                      m_tready,
   output logic                      m_tlast,
   output logic                      busy,
   output logic                      done
);
   localparam int BEATS  = FRAME_SAMPLES / LANES;
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

   if ((FRAME_SAMPLES % LANES) != 0) begin : g_bad_frame
      $error("FRAME_SAMPLES must be a multiple of LANES");
   end
   if (BEATS < 2) begin : g_bad_beats
      $error("a frame must span at least two beats");
   end
   if (NF_W < 1) begin : g_bad_nf
      $error("NF_W must be at least 1");
   end

   logic              start;
   logic              hs;
   logic              beat_last;
   logic              frame_last;
   logic              final_beat;
   logic [BEAT_W-1:0] beat_cnt;
   logic [NF_W-1:0]   frame_cnt;
   logic [NF_W-1:0]   nf_q;

   assign hs         = busy && s_valid && m_tready;
   assign final_beat = hs && beat_last && frame_last;

   wcap_ctrl #(.NF_W(NF_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig       (trig),
      .n_frames   (n_frames),
      .final_beat (final_beat),
      .busy       (busy),
      .done       (done),
      .start      (start),
      .nf_q       (nf_q)
   );

   wcap_wrap_cnt #(.W(BEAT_W)) u_beat (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .inc      (hs),
      .last_val (BEAT_W'(BEATS - 1)),
      .cnt      (beat_cnt),
      .at_last  (beat_last)
   );

   wcap_wrap_cnt #(.W(NF_W)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .inc      (hs && beat_last),
      .last_val (nf_q - 1'b1),
      .cnt      (frame_cnt),
      .at_last  (frame_last)
   );

   assign s_ready  = busy ? m_tready : 1'b1;
   assign m_tvalid = busy && s_valid;
   assign m_tdata  = s_data;
   assign m_tlast  = m_tvalid && beat_last;
endmodule

// File: rtl/wcap_checker.sv
module wcap_checker #(
   parameter int NF_W = 11
) (
   input logic            clk,
   input logic            rst_n,
   input logic            trig,
   input logic [NF_W-1:0] n_frames,
   input logic            busy,
   input logic            done,
   input logic            m_tvalid,
   input logic            m_tready,
   input logic            m_tlast
);
   AST_TLAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      m_tlast |-> m_tvalid); // R2
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !m_tvalid); // R7
   AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trig && n_frames != '0) |=> busy); // R3
   AST_ZERO_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && trig && n_frames == '0) |=> !busy); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(m_tvalid && m_tready && m_tlast)); // R5
   AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R5
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R5
endmodule

bind win_capture wcap_checker #(.NF_W(NF_W)) u_wcap_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .trig     (trig),
   .n_frames (n_frames),
   .busy     (busy),
   .done     (done),
   .m_tvalid (m_tvalid),
   .m_tready (m_tready),
   .m_tlast  (m_tlast)
);

// File: tb/win_capture_bench.sv
module win_capture_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NF_W = 11;
   localparam int DW = 128;
   localparam int NVEC = 6;
   // nf, ready mode, valid mode, idle lead cycles
   localparam int VEC [NVEC][4] = '{
      '{1, 0, 0, 0},
      '{2, 1, 0, 37},
      '{3, 2, 1, 200},
      '{1, 0, 1, 129},
      '{4, 1, 1, 5},
      '{2, 2, 0, 64}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DW-1:0] s_data = '0;
   logic s_valid = 1'b0;
   logic s_ready;
   logic trig = 1'b0;
   logic [NF_W-1:0] n_frames = '0;
   logic [DW-1:0] m_tdata;
   logic m_tvalid;
   logic m_tready = 1'b0;
   logic m_tlast;
   logic busy;
   logic done;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int src_idx = 0;
   logic o_hs;

   always #(CLK_PERIOD/2) clk = ~clk;

   win_capture u_win_capture (
      .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid),
      .s_ready(s_ready), .trig(trig), .n_frames(n_frames),
      .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
      .m_tlast(m_tlast), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pack(input int idx);
      logic [DW-1:0] d;
      for (int k = 0; k < 4; k++) begin
         d[32*k +: 16]      = 16'((idx*4 + k) % 512);
         d[32*k + 16 +: 16] = 16'(idx / 128);
      end
      return d;
   endfunction

   function automatic logic rdy_of(input int mode);
      if (mode == 1) return cyc[0];
      if (mode == 2) return (cyc % 4) == 0;
      return 1'b1;
   endfunction

   function automatic logic vld_of(input int mode);
      if (mode == 1) return (cyc % 3) != 2;
      return 1'b1;
   endfunction

   task automatic step(input logic t, input logic r, input logic v, input int nfv);
      @(negedge clk);
      trig = t; m_tready = r; s_valid = v; n_frames = NF_W'(nfv);
      s_data = pack(src_idx);
      #1;
      o_hs = m_tvalid && m_tready;
      if (s_valid && s_ready) src_idx++;
      cyc++;
   endtask

   task automatic run_window(input int nf, input int rm, input int vm, input int lead,
                             input bit trig_last, input bit trig_done);
      int total, n, tl, bad_tl, bad_data, bad_done, first, im0, im127, guard;
      bit fin, got_done;
      total = nf * 128; n = 0; tl = 0; bad_tl = 0; bad_data = 0; bad_done = 0;
      fin = 0; got_done = 0; im0 = 0; im127 = 0; guard = 0;
      for (int i = 0; i < lead; i++) begin
         step(1'b0, rdy_of(rm), vld_of(vm), 7);
         if (m_tvalid) bad_data++;
      end
      step(1'b1, rdy_of(rm), vld_of(vm), nf);
      chk(!m_tvalid && s_ready, "R7 idle drop in trigger cycle", m_tvalid, 0);
      first = src_idx;
      while (!got_done && guard < total * 6 + 100) begin
         logic t;
         guard++;
         t = (n == 3) || (trig_last && n == total - 1) || (fin && trig_done);
         step(t, rdy_of(rm), vld_of(vm), (fin && trig_done) ? 1 : 7);
         if (fin) begin
            chk(done && !busy, "R5 done pulse with busy low", done, 1);
            got_done = 1;
         end else begin
            if (done || !busy) bad_done++;
            if (o_hs) begin
               logic [DW-1:0] e;
               e = pack(first + n);
               if (m_tlast != ((n % 128) == 127)) bad_tl++;
               if (m_tlast) tl++;
               if (m_tdata != e) bad_data++;
               if (n == 0) begin
                  im0 = int'(m_tdata[31:16]);
                  chk(int'(m_tdata[15:0]) == (first*4) % 512, "R3 first beat follows trigger",
                      int'(m_tdata[15:0]), (first*4) % 512);
               end
               if (n == 127) im127 = int'(m_tdata[31:16]);
               n++;
               if (n == total) fin = 1;
            end
         end
      end
      chk(n == total, "R1 beat count", n, total);
      chk(tl == nf && bad_tl == 0, "R2 tlast placement", tl, nf);
      chk(bad_data == 0, "R6 data order", bad_data, 0);
      chk(bad_done == 0, "R5 no early done", bad_done, 0);
      if ((first % 128) != 0)
         chk(im0 != im127, "R2 frame spans two upstream frames", im127, im0 + 1);
      if (trig_done) begin
         int m;
         step(1'b0, 1'b1, 1'b1, 7);
         chk(busy == 1'b1, "R4 trigger in done cycle accepted", busy, 1);
         m = 1; got_done = 0;
         for (int i = 0; i < 400 && !got_done; i++) begin
            step(1'b0, 1'b1, 1'b1, 7);
            if (done) got_done = 1; else if (o_hs) m++;
         end
         chk(m == 128 && got_done, "R4 chained window length", m, 128);
      end else begin
         step(1'b0, rdy_of(rm), vld_of(vm), 7);
         chk(!busy && !done, "R4 ignored trigger leaves idle", busy, 0);
      end
   endtask

   initial begin
      int wd = 0;
      while (wd < 195000) begin
         @(posedge clk);
         wd++;
      end
      chk(1'b0, "watchdog", wd, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) step(1'b0, 1'b0, 1'b1, 7);
      chk(!busy && !done && !m_tvalid && !m_tlast, "R9 reset state", busy, 0);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b1, 7);
      chk(s_ready && !m_tvalid, "R7 idle with ready low", s_ready, 1);
      for (int v = 0; v < NVEC; v++)
         run_window(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0, 1'b0);
      run_window(2, 0, 0, 11, 1'b1, 1'b0);
      run_window(1, 0, 0, 3, 1'b0, 1'b1);
      step(1'b1, 1'b1, 1'b1, 0);
      step(1'b0, 1'b1, 1'b1, 7);
      chk(!busy && !m_tvalid, "R8 zero frames ignored", busy, 0);
      step(1'b0, 1'b1, 1'b1, 7);
      chk(!done, "R8 no done for zero frames", done, 0);
      run_window(1024, 0, 0, 1, 1'b0, 1'b0); // R10
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule